// File: doc/BRIEF.md
# Charger Option Control Register

A 16-bit host-programmable option register for a battery charge controller. The host reaches it through a simple write/read port at register address 8'h12. The register holds the charger's mode enables and turns them into a set of registered digital control outputs. Those outputs are the low-power gating of the monitor and comparator enables, a charger-OK status that can be forced high while the charger runs in OTG (reverse supply) mode, and a flag that asks for the minimum burst frequency to stay above the audible band.

The register is not only changed by the host. When the auto-disable option is set and the battery-present input falls, the hardware clears the input current limit enable bit itself. That bit then stays cleared until the host writes it back. The analog monitors, the ADC, the power stage and the physical serial bus lie outside this block. Their enables are modelled here as plain digital outputs.

Top module: `chg_opt_reg`

## Requirements
- R1: After reset the register reads 16'hE20E. Every derived output is 0 until the first clock edge after reset is released.
- R2: A host write with `host_addr` = 8'h12 loads all 16 bits. A read at 8'h12 returns the full register contents on `host_rdata` one cycle after `host_rd`. A read at any other address returns 0.
- R3: A host write to any address other than 8'h12 leaves the register unchanged.
- R4: When bit 15 (low-power) is 1, `prochot_en`, `dchg_mon_en`, `pwr_mon_en` and `adc_avail` are 0. When bit 15 is 0, all four are 1.
- R5: `ind_cmp_en` is 1 when bit 15 is 0, or when any bit of `cmp_req` is 1. Otherwise it is 0.
- R6: When bit 12 (auto-disable) is 1 and `bat_present` goes from 1 to 0, bit 1 (input current limit enable) is cleared in the register.
- R7: After a hardware clear, bit 1 stays 0 even if `bat_present` returns to 1. It becomes 1 again only through a host write.
- R8: When bit 12 is 0, a falling `bat_present` leaves the register unchanged.
- R9: A host write to 8'h12 in the same cycle as a hardware clear takes priority. The register takes the written value.
- R10: `chg_ok` is 1 when `chg_ok_in` is 1, or when bit 11 (OTG-on-charger-OK) is 1 and `otg_mode` is 1.
- R11: `burst_floor_req` (keep the minimum burst frequency above 25 kHz) follows bit 10.
- R12: `wdog_sel` follows bits 14:13 and `ilim_en` follows bit 1.
- R13: Each derived output is registered. It reflects the register contents and inputs as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Registered read data |
| bat_present | input | 1 | Battery-present level, synchronous |
| otg_mode | input | 1 | Charger is in OTG mode |
| chg_ok_in | input | 1 | Base charger-OK condition |
| cmp_req | input | 2 | External independent-comparator enable requests |
| prochot_en | output | 1 | Processor-hot monitor enable |
| dchg_mon_en | output | 1 | Discharge current monitor enable |
| pwr_mon_en | output | 1 | Power monitor enable |
| ind_cmp_en | output | 1 | Independent comparator enable |
| adc_avail | output | 1 | ADC available |
| chg_ok | output | 1 | Charger-OK status |
| burst_floor_req | output | 1 | Minimum burst frequency floor request |
| ilim_en | output | 1 | Input current limit enable |
| wdog_sel | output | 2 | Watchdog period select |

## Verification
The hardest case to reach is a host write landing in the same cycle as a hardware clear (R9). That needs the auto-disable bit already set, `bat_present` high on the previous cycle and low on the current one, and a write strobe at the matching address, all together. Directed sequences set up this collision and the lingering-clear case of R7 explicitly. A seeded random phase then toggles `bat_present` often while writing random option values, so collisions also occur in mixed states. A cycle-accurate bench model predicts every output in that phase.

// File: rtl/chg_opt_pkg.sv
package chg_opt_pkg;
  localparam int OPT_W     = 16;
  localparam int B_LOWPWR  = 15;
  localparam int B_WDOG_HI = 14;
  localparam int B_WDOG_LO = 13;
  localparam int B_AUTOCLR = 12;
  localparam int B_OTGOK   = 11;
  localparam int B_QUIET   = 10;
  localparam int B_ILIM    = 1;

  typedef struct packed {
    logic       prochot_en;
    logic       dchg_mon_en;
    logic       pwr_mon_en;
    logic       ind_cmp_en;
    logic       adc_avail;
    logic       chg_ok;
    logic       burst_floor;
    logic       ilim_en;
    logic [1:0] wdog_sel;
  } ctrl_out_t;
endpackage

// File: rtl/chg_opt_store.sv
module chg_opt_store
  import chg_opt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = OPT_W,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h12,
  parameter logic [DATA_W-1:0] RST_VAL  = 16'hE20E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              bat_present,
  output logic [DATA_W-1:0] opt_q
);
  logic bat_d;
  logic wr_hit;
  logic bat_fall;
  logic hw_clr;

  assign wr_hit   = host_wr && (host_addr == REG_ADDR);
  assign bat_fall = bat_d && !bat_present;
  assign hw_clr   = bat_fall && opt_q[B_AUTOCLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q <= RST_VAL;
      bat_d <= 1'b0;
    end else begin
      bat_d <= bat_present;
      if (wr_hit)
        opt_q <= host_wdata;
      else if (hw_clr)
        opt_q[B_ILIM] <= 1'b0;
    end
  end

  // R6: armed falling edge clears the limit enable
  p_hw_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (bat_d && !bat_present && opt_q[B_AUTOCLR] && !wr_hit) |=> !opt_q[B_ILIM]);
  // R7: a cleared limit enable returns only by a host write
  p_hold_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (!opt_q[B_ILIM] && !wr_hit) |=> !opt_q[B_ILIM]);
  // R3, R8: without a matching write the other bits never move
  p_no_stray_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> (opt_q[DATA_W-1:B_ILIM+1] == $past(opt_q[DATA_W-1:B_ILIM+1]))
                && (opt_q[0] == $past(opt_q[0])));
  // R9: host write wins over a concurrent hardware clear
  p_wr_prio_r9: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> opt_q == $past(host_wdata));
endmodule

// File: rtl/chg_opt_ctrl.sv
module chg_opt_ctrl
  import chg_opt_pkg::*;
#(
  parameter int DATA_W = OPT_W,
  parameter int NUM_REQ = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  opt_q,
  input  logic               otg_mode,
  input  logic               chg_ok_in,
  input  logic [NUM_REQ-1:0] cmp_req,
  output ctrl_out_t          ctl
);
  logic lp;
  logic any_req;
  logic [NUM_REQ:0] req_chain;

  assign lp = opt_q[B_LOWPWR];

  assign req_chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req_or
    assign req_chain[g+1] = req_chain[g] | cmp_req[g];
  end
  assign any_req = req_chain[NUM_REQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else begin
      ctl.prochot_en  <= !lp;
      ctl.dchg_mon_en <= !lp;
      ctl.pwr_mon_en  <= !lp;
      ctl.adc_avail   <= !lp;
      ctl.ind_cmp_en  <= !lp || any_req;
      ctl.chg_ok      <= chg_ok_in || (opt_q[B_OTGOK] && otg_mode);
      ctl.burst_floor <= opt_q[B_QUIET];
      ctl.ilim_en     <= opt_q[B_ILIM];
      ctl.wdog_sel    <= opt_q[B_WDOG_HI:B_WDOG_LO];
    end
  end

  // R4: low-power mode gates the monitors off
  p_lp_gate_r4: assert property (@(posedge clk) disable iff (rst)
    opt_q[B_LOWPWR] |=> !ctl.prochot_en && !ctl.dchg_mon_en && !ctl.pwr_mon_en && !ctl.adc_avail);
  // R4: performance mode enables the monitors
  p_perf_on_r4: assert property (@(posedge clk) disable iff (rst)
    !opt_q[B_LOWPWR] |=> ctl.prochot_en && ctl.dchg_mon_en && ctl.pwr_mon_en && ctl.adc_avail);
  // R5: an external request keeps the comparator alive
  p_cmp_req_r5: assert property (@(posedge clk) disable iff (rst)
    (|cmp_req) |=> ctl.ind_cmp_en);
  // R10: OTG forces charger-OK when enabled
  p_otg_ok_r10: assert property (@(posedge clk) disable iff (rst)
    (opt_q[B_OTGOK] && otg_mode) |=> ctl.chg_ok);
endmodule

// File: rtl/chg_opt_reg.sv
module chg_opt_reg
  import chg_opt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = OPT_W,
  parameter int NUM_REQ = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h12,
  parameter logic [DATA_W-1:0] RST_VAL  = 16'hE20E
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               host_wr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic               host_rd,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               bat_present,
  input  logic               otg_mode,
  input  logic               chg_ok_in,
  input  logic [NUM_REQ-1:0] cmp_req,
  output logic               prochot_en,
  output logic               dchg_mon_en,
  output logic               pwr_mon_en,
  output logic               ind_cmp_en,
  output logic               adc_avail,
  output logic               chg_ok,
  output logic               burst_floor_req,
  output logic               ilim_en,
  output logic [1:0]         wdog_sel
);
  logic [DATA_W-1:0] opt_q;
  ctrl_out_t         ctl;

  chg_opt_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .RST_VAL(RST_VAL)
  ) i_store (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .bat_present(bat_present), .opt_q(opt_q)
  );

  chg_opt_ctrl #(.DATA_W(DATA_W), .NUM_REQ(NUM_REQ)) i_ctrl (
    .clk(clk), .rst(rst), .opt_q(opt_q), .otg_mode(otg_mode),
    .chg_ok_in(chg_ok_in), .cmp_req(cmp_req), .ctl(ctl)
  );

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= '0;
    else if (host_rd)
      host_rdata <= (host_addr == REG_ADDR) ? opt_q : '0;
  end

  assign prochot_en      = ctl.prochot_en;
  assign dchg_mon_en     = ctl.dchg_mon_en;
  assign pwr_mon_en      = ctl.pwr_mon_en;
  assign ind_cmp_en      = ctl.ind_cmp_en;
  assign adc_avail       = ctl.adc_avail;
  assign chg_ok          = ctl.chg_ok;
  assign burst_floor_req = ctl.burst_floor;
  assign ilim_en         = ctl.ilim_en;
  assign wdog_sel        = ctl.wdog_sel;

  // R2: a matching read returns the register one cycle later
  p_read_r2: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == REG_ADDR) |=> host_rdata == $past(opt_q));
  // R12: limit enable output tracks the stored bit
  p_ilim_r12: assert property (@(posedge clk) disable iff (rst)
    opt_q[B_ILIM] |=> ilim_en);
endmodule

// File: tb/test_chg_opt_reg.sv
module test_chg_opt_reg;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  host_addr;
  logic        host_wr;
  logic [15:0] host_wdata;
  logic        host_rd;
  logic [15:0] host_rdata;
  logic        bat_present, otg_mode, chg_ok_in;
  logic [1:0]  cmp_req;
  logic        prochot_en, dchg_mon_en, pwr_mon_en, ind_cmp_en, adc_avail;
  logic        chg_ok, burst_floor_req, ilim_en;
  logic [1:0]  wdog_sel;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] m_reg;
  logic        m_bat;
  logic [15:0] e_rdata;
  logic [9:0]  e_out;

  always #10 clk = ~clk;

  chg_opt_reg i_chg_opt_reg (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .bat_present(bat_present), .otg_mode(otg_mode), .chg_ok_in(chg_ok_in),
    .cmp_req(cmp_req), .prochot_en(prochot_en), .dchg_mon_en(dchg_mon_en),
    .pwr_mon_en(pwr_mon_en), .ind_cmp_en(ind_cmp_en), .adc_avail(adc_avail),
    .chg_ok(chg_ok), .burst_floor_req(burst_floor_req), .ilim_en(ilim_en),
    .wdog_sel(wdog_sel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {prochot, dchg, pwr, ind_cmp, adc, chg_ok, burst, ilim, wdog[1:0]}
  function automatic logic [9:0] model_out(input logic [15:0] r, input logic otg,
                                           input logic cin, input logic [1:0] req);
    logic lp;
    lp = r[15];
    return {!lp, !lp, !lp, (!lp || (req != 2'b00)), !lp,
            (cin || (r[11] && otg)), r[10], r[1], r[14:13]};
  endfunction

  task automatic check_outputs();
    check("R2 rdata", {16'h0, host_rdata}, {16'h0, e_rdata});
    check("R4 monitor gating", {29'h0, prochot_en, dchg_mon_en, pwr_mon_en},
          {29'h0, e_out[9], e_out[8], e_out[7]});
    check("R4 adc", {31'h0, adc_avail}, {31'h0, e_out[5]});
    check("R5 ind_cmp", {31'h0, ind_cmp_en}, {31'h0, e_out[6]});
    check("R10 chg_ok", {31'h0, chg_ok}, {31'h0, e_out[4]});
    check("R11 burst", {31'h0, burst_floor_req}, {31'h0, e_out[3]});
    check("R12 ilim/wdog", {29'h0, ilim_en, wdog_sel}, {29'h0, e_out[2], e_out[1:0]});
  endtask

  // drive at negedge, model at posedge, check at the next negedge (R13)
  task automatic step(input logic [7:0] a, input logic wr, input logic [15:0] wd,
                      input logic rd, input logic bat, input logic otg,
                      input logic cin, input logic [1:0] req);
    logic fall;
    host_addr = a; host_wr = wr; host_wdata = wd; host_rd = rd;
    bat_present = bat; otg_mode = otg; chg_ok_in = cin; cmp_req = req;
    @(posedge clk);
    e_out = model_out(m_reg, otg, cin, req);
    if (rd) e_rdata = (a == 8'h12) ? m_reg : 16'h0;
    fall = m_bat && !bat;
    m_bat = bat;
    if (wr && a == 8'h12) m_reg = wd;
    else if (fall && m_reg[12]) m_reg[1] = 1'b0;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic rd_expect(input string tag, input logic [15:0] exp);
    step(8'h12, 1'b0, 16'h0, 1'b1, m_bat, 1'b0, 1'b0, 2'b00);
    check(tag, {16'h0, host_rdata}, {16'h0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; host_addr = 8'h0; host_wr = 0; host_wdata = 0; host_rd = 0;
    bat_present = 0; otg_mode = 0; chg_ok_in = 0; cmp_req = 0;
    m_reg = 16'hE20E; m_bat = 1'b0; e_rdata = 16'h0; e_out = 10'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: outputs all zero out of reset
    check("R1 outputs at reset", {22'h0, prochot_en, dchg_mon_en, pwr_mon_en, ind_cmp_en,
          adc_avail, chg_ok, burst_floor_req, ilim_en, wdog_sel}, 32'h0);
    rd_expect("R1 reset value", 16'hE20E);

    // R3: other address ignored
    step(8'h13, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
    rd_expect("R3 foreign write", 16'hE20E);
    step(8'h13, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    check("R2 foreign read", {16'h0, host_rdata}, 32'h0);

    // R4/R5: low power with comparator requests
    step(8'h00, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10);
    check("R5 request in low power", {31'h0, ind_cmp_en}, 32'h1);
    step(8'h12, 1'b1, 16'h0C02, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00);
    step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00);
    check("R4 performance mode", {31'h0, prochot_en}, 32'h1);
    check("R10 otg forces ok", {31'h0, chg_ok}, 32'h1);
    check("R11 quiet flag", {31'h0, burst_floor_req}, 32'h1);

    // R6/R7: auto clear and sticky
    step(8'h12, 1'b1, 16'h1002, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
    step(8'h00, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
    rd_expect("R6 auto clear", 16'h1000);
    step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
    step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
    rd_expect("R7 stays cleared", 16'h1000);
    check("R7 ilim output low", {31'h0, ilim_en}, 32'h0);
    step(8'h12, 1'b1, 16'h1002, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
    rd_expect("R7 host restores", 16'h1002);

    // R9: write collides with clear
    step(8'h12, 1'b1, 16'h1006, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
    rd_expect("R9 write priority", 16'h1006);

    // R8: auto disable off
    step(8'h12, 1'b1, 16'h0002, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
    step(8'h00, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
    rd_expect("R8 no clear", 16'h0002);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [15:0] d;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'h12;
      d = 16'($urandom);
      if ($urandom % 2 == 0) d[12] = 1'b1;
      step(a, ($urandom % 5 == 0), d, ($urandom % 2 == 0), 1'($urandom),
           1'($urandom), ($urandom % 4 == 0), 2'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule